// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the two error counters of a CAN node and derives from them the node's fault confinement state: error active, error passive or bus off. The protocol engine around it supplies single-cycle event pulses (transmit error, receive error, acknowledge error seen while transmitting, good transmission, good reception). While the node is bus off, it also supplies every sampled bus bit with a valid strobe. The block reports the counters, a two-bit state code, and a one-cycle pulse when the node goes bus off.

Transmit errors add 8 to the transmit counter and receive errors add 1 to the receive counter. Each success takes one off its own counter, and neither counter goes below zero. The receive counter stops at 128. A good reception while it sits there reloads it to 127. An overflow of the transmit counter puts the node bus off. Recovery from bus off needs 128 runs of 11 consecutive recessive bits. The transmit counter counts these runs, and a small run counter counts the bits within each run. All outputs are registered, so every output reflects the events of the previous clock.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous active-high reset sets both counters to zero, the state to error active (code 00) and the bus-off pulse low.
- R2: Outside bus off, a transmit error adds 8 to the transmit counter. A good transmission takes off 1, but not below zero. If both arrive in the same cycle, the error wins.
- R3: Outside bus off, a receive error adds 1 to the receive counter. A good reception takes off 1, but not below zero. If both arrive in the same cycle, the error wins.
- R4: When either counter is 128 or more, the state code is 01 (error passive). Code 11 never appears.
- R5: From error passive, the state returns to error active (00) as soon as both counters are 127 or less.
- R6: An acknowledge error adds 8 to the transmit counter in error active and has no effect in error passive.
- R7: A receive error leaves a receive counter that is above 127 unchanged, so the counter never exceeds 128. A good reception while it is above 127 sets it to exactly 127.
- R8: A transmit error that would take the transmit counter past 255 sets the state to bus off (code 10) and clears the transmit counter. In the next cycle, the bus-off pulse is high for exactly one cycle.
- R9: In bus off, error and success pulses change neither counter.
- R10: In bus off, every 11 consecutive valid recessive bits (bus bit 1) add 1 to the transmit counter. A valid dominant bit (bus bit 0) before the 11th clears the run without changing the transmit counter. Bits without the valid strobe are ignored.
- R11: When the transmit counter reaches 128 in bus off, the state becomes error active and both counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_err | input | 1 | Transmit error pulse |
| rx_err | input | 1 | Receive error pulse |
| ack_err | input | 1 | Acknowledge error pulse while transmitting |
| tx_ok | input | 1 | Good transmission pulse |
| rx_ok | input | 1 | Good reception pulse |
| bit_vld | input | 1 | Sampled bus bit strobe |
| bit_rec | input | 1 | Sampled bus bit, 1 = recessive |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| fc_state | output | 2 | 00 active, 01 passive, 10 bus off |
| boff_pulse | output | 1 | One-cycle pulse on entry to bus off |

## Verification
A wrong internal value shows at the counter ports one clock after the event that exposes it, because every output is registered. A broken state decision shows as a wrong code on the first event that crosses the 127/128 boundary or overflows the transmit counter. A wrong count in the hidden run counter is seen only at the transmit counter, when a run completes early or late, so the bench places dominant bits and invalid strobes just before the eleventh bit. A run-counter fault is therefore visible within one run, and the recovery exit is visible after all 128 runs.

// File: rtl/can_fc_pkg.sv
`timescale 1ns/1ps
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/can_fc_run_ctr.sv
`timescale 1ns/1ps
module can_fc_run_ctr #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic in_boff,
  input  logic bit_vld,
  input  logic bit_rec,
  output logic run_wrap
);
  localparam int RUN_W = $clog2(RUN_LEN);

  logic [RUN_W-1:0] run_q;

  assign run_wrap = in_boff && bit_vld && bit_rec && (run_q == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !in_boff) begin
      run_q <= '0;
    end else if (bit_vld) begin
      if (!bit_rec || run_wrap) run_q <= '0;
      else                      run_q <= run_q + 1'b1;
    end
  end

  AST_RUN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_q < RUN_W'(RUN_LEN)); // R10
  AST_DOMINANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (in_boff && bit_vld && !bit_rec) |=> (run_q == '0)); // R10
endmodule

// File: rtl/can_fc_tx_ctr.sv
`timescale 1ns/1ps
module can_fc_tx_ctr
  import can_fc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int ERR_STEP   = 8,
  parameter int RECOV_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  fc_state_e        st,
  input  logic             tx_err,
  input  logic             ack_err,
  input  logic             tx_ok,
  input  logic             run_wrap,
  output logic [CNT_W-1:0] tec_q,
  output logic [CNT_W-1:0] tec_nxt,
  output logic             boff_enter,
  output logic             recov_done
);
  localparam int SUM_W = CNT_W + 1;

  logic             in_boff;
  logic             inc;
  logic [SUM_W-1:0] sum;

  assign in_boff    = st[1];
  assign inc        = tx_err || (ack_err && st == FC_ACTIVE);
  assign sum        = {1'b0, tec_q} + SUM_W'(ERR_STEP);
  assign boff_enter = !in_boff && inc && sum[CNT_W];
  assign recov_done = in_boff && run_wrap && (tec_q == CNT_W'(RECOV_RUNS - 1));

  always_comb begin
    tec_nxt = tec_q;
    if (in_boff) begin
      if (recov_done)    tec_nxt = '0;
      else if (run_wrap) tec_nxt = tec_q + 1'b1;
    end else if (inc) begin
      tec_nxt = boff_enter ? '0 : sum[CNT_W-1:0];
    end else if (tx_ok && tec_q != '0) begin
      tec_nxt = tec_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tec_q <= '0;
    else     tec_q <= tec_nxt;
  end

  AST_ACK_IGNORED_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    (st == FC_PASSIVE && ack_err && !tx_err && !tx_ok) |=> (tec_q == $past(tec_q))); // R6
  AST_BOFF_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (in_boff && !run_wrap) |=> (tec_q == $past(tec_q))); // R9
endmodule

// File: rtl/can_fc_rx_ctr.sv
`timescale 1ns/1ps
module can_fc_rx_ctr #(
  parameter int CNT_W   = 8,
  parameter int LIMIT   = 128,
  parameter int RELOAD  = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_boff,
  input  logic             clr,
  input  logic             rx_err,
  input  logic             rx_ok,
  output logic [CNT_W-1:0] rec_q,
  output logic [CNT_W-1:0] rec_nxt
);
  logic high;

  assign high = rec_q >= CNT_W'(LIMIT);

  always_comb begin
    rec_nxt = rec_q;
    if (in_boff) begin
      if (clr) rec_nxt = '0;
    end else if (rx_err) begin
      if (!high) rec_nxt = rec_q + 1'b1;
    end else if (rx_ok) begin
      if (high)                rec_nxt = CNT_W'(RELOAD);
      else if (rec_q != '0)    rec_nxt = rec_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= '0;
    else     rec_q <= rec_nxt;
  end

  AST_REC_CAP: assert property (@(posedge clk) disable iff (rst)
    rec_q <= CNT_W'(LIMIT)); // R7
  AST_REC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!in_boff && rx_ok && !rx_err && high) |=> (rec_q == CNT_W'(RELOAD))); // R7
endmodule

// File: rtl/can_fault_conf.sv
`timescale 1ns/1ps
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PASS_LIM   = 128,
  parameter int ERR_STEP   = 8,
  parameter int REC_RELOAD = 127,
  parameter int RUN_LEN    = 11,
  parameter int RECOV_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             ack_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             bit_vld,
  input  logic             bit_rec,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       fc_state,
  output logic             boff_pulse
);
  fc_state_e        st_q, st_nxt;
  logic             run_wrap, boff_enter, recov_done;
  logic [CNT_W-1:0] tec_nxt, rec_nxt;

  can_fc_run_ctr #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .in_boff(st_q[1]),
    .bit_vld(bit_vld), .bit_rec(bit_rec), .run_wrap(run_wrap)
  );

  can_fc_tx_ctr #(.CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .RECOV_RUNS(RECOV_RUNS)) u_tx (
    .clk(clk), .rst(rst), .st(st_q), .tx_err(tx_err), .ack_err(ack_err),
    .tx_ok(tx_ok), .run_wrap(run_wrap), .tec_q(tec), .tec_nxt(tec_nxt),
    .boff_enter(boff_enter), .recov_done(recov_done)
  );

  can_fc_rx_ctr #(.CNT_W(CNT_W), .LIMIT(PASS_LIM), .RELOAD(REC_RELOAD)) u_rx (
    .clk(clk), .rst(rst), .in_boff(st_q[1]), .clr(recov_done),
    .rx_err(rx_err), .rx_ok(rx_ok), .rec_q(rec), .rec_nxt(rec_nxt)
  );

  always_comb begin
    if (st_q[1])
      st_nxt = recov_done ? FC_ACTIVE : FC_BUSOFF;
    else if (boff_enter)
      st_nxt = FC_BUSOFF;
    else if (tec_nxt >= CNT_W'(PASS_LIM) || rec_nxt >= CNT_W'(PASS_LIM))
      st_nxt = FC_PASSIVE;
    else
      st_nxt = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= FC_ACTIVE;
      boff_pulse <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      boff_pulse <= boff_enter;
    end
  end

  assign fc_state = st_q;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fc_state != 2'b11); // R4
  AST_BOFF_TEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    boff_pulse |-> (st_q == FC_BUSOFF && tec == '0)); // R8
  AST_BOFF_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    boff_pulse |=> !boff_pulse); // R8
  AST_RECOVERY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (st_q == FC_ACTIVE && $past(st_q) == FC_BUSOFF) |-> (tec == '0 && rec == '0)); // R11
endmodule

// File: tb/can_fault_conf_bench.sv
`timescale 1ns/1ps
module can_fault_conf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_err = 0, rx_err = 0, ack_err = 0, tx_ok = 0, rx_ok = 0;
  logic       bit_vld = 0, bit_rec = 1;
  logic [7:0] tec, rec;
  logic [1:0] fc_state;
  logic       boff_pulse;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  can_fault_conf u_can_fault_conf (
    .clk(clk), .rst(rst), .tx_err(tx_err), .rx_err(rx_err), .ack_err(ack_err),
    .tx_ok(tx_ok), .rx_ok(rx_ok), .bit_vld(bit_vld), .bit_rec(bit_rec),
    .tec(tec), .rec(rec), .fc_state(fc_state), .boff_pulse(boff_pulse)
  );

  // {tx_err, rx_err, ack_err, tx_ok, rx_ok, tec, rec, state}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {5'b01000, 8'd0,  8'd1, 2'b00},  // R3 rx error
    {5'b01000, 8'd0,  8'd2, 2'b00},  // R3
    {5'b00001, 8'd0,  8'd1, 2'b00},  // R3 good rx
    {5'b00001, 8'd0,  8'd0, 2'b00},  // R3
    {5'b00001, 8'd0,  8'd0, 2'b00},  // R3 floor
    {5'b01001, 8'd0,  8'd1, 2'b00},  // R3 error wins
    {5'b10000, 8'd8,  8'd1, 2'b00},  // R2 tx error
    {5'b00010, 8'd7,  8'd1, 2'b00},  // R2 good tx
    {5'b10010, 8'd15, 8'd1, 2'b00},  // R2 error wins
    {5'b00100, 8'd23, 8'd1, 2'b00},  // R6 ack in active
    {5'b11000, 8'd31, 8'd2, 2'b00},  // R2 R3 together
    {5'b00001, 8'd31, 8'd1, 2'b00}   // R3
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ev(input logic [4:0] e);
    {tx_err, rx_err, ack_err, tx_ok, rx_ok} = e;
    @(negedge clk);
    {tx_err, rx_err, ack_err, tx_ok, rx_ok} = '0;
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      bit_vld = 1'b1; bit_rec = v;
      @(negedge clk);
    end
    bit_vld = 1'b0; bit_rec = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "tec", tec, 0);
    chk("R1", "rec", rec, 0);
    chk("R1", "state", fc_state, 0);
    chk("R1", "boff_pulse", boff_pulse, 0);

    for (int i = 0; i < NV; i++) begin
      ev(VEC[i][22:18]);
      chk("R2/R3/R6 vec", "tec", tec, VEC[i][17:10]);
      chk("R2/R3/R6 vec", "rec", rec, VEC[i][9:2]);
      chk("R2/R3/R6 vec", "state", fc_state, VEC[i][1:0]);
    end

    // R4 passive threshold on tec
    for (int i = 0; i < 12; i++) ev(5'b10000);
    chk("R4", "tec 127", tec, 127);
    chk("R4", "state at 127", fc_state, 0);
    ev(5'b10000);
    chk("R4", "tec 135", tec, 135);
    chk("R4", "state passive", fc_state, 1);
    // R6 ack ignored in passive
    ev(5'b00100);
    chk("R6", "tec after ack", tec, 135);
    chk("R6", "state after ack", fc_state, 1);
    // R5 return to active
    for (int i = 0; i < 7; i++) ev(5'b00010);
    chk("R5", "state at 128", fc_state, 1);
    ev(5'b00010);
    chk("R5", "tec 127", tec, 127);
    chk("R5", "state active", fc_state, 0);

    // R1 mid-run reset
    do_reset();
    chk("R1", "tec after reset", tec, 0);
    chk("R1", "rec after reset", rec, 0);

    // R7 receive saturation
    for (int i = 0; i < 128; i++) ev(5'b01000);
    chk("R4", "rec 128 passive", fc_state, 1);
    ev(5'b01000);
    chk("R7", "rec saturated", rec, 128);
    ev(5'b00001);
    chk("R7", "rec reload", rec, 127);
    chk("R5", "active after reload", fc_state, 0);

    // R8 bus off
    do_reset();
    for (int i = 0; i < 5; i++) ev(5'b01000);
    for (int i = 0; i < 31; i++) ev(5'b10000);
    chk("R8", "tec 248", tec, 248);
    chk("R8", "passive before", fc_state, 1);
    ev(5'b10000);
    chk("R8", "bus off state", fc_state, 2);
    chk("R8", "tec cleared", tec, 0);
    chk("R8", "pulse high", boff_pulse, 1);
    @(negedge clk);
    chk("R8", "pulse low", boff_pulse, 0);

    // R9 events ignored in bus off
    ev(5'b10000); ev(5'b01000); ev(5'b00100); ev(5'b00010); ev(5'b00001);
    chk("R9", "tec frozen", tec, 0);
    chk("R9", "rec frozen", rec, 5);
    chk("R9", "still bus off", fc_state, 2);

    // R10 runs
    bits(10, 1'b1);
    bits(1, 1'b0);
    chk("R10", "dominant breaks run", tec, 0);
    bits(10, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10", "invalid bits ignored", tec, 0);
    bits(1, 1'b1);
    chk("R10", "run completes", tec, 1);
    for (int r = 0; r < 126; r++) bits(11, 1'b1);
    chk("R10", "tec 127", tec, 127);
    chk("R11", "still bus off", fc_state, 2);
    bits(11, 1'b1);
    chk("R11", "recovered state", fc_state, 0);
    chk("R11", "tec cleared", tec, 0);
    chk("R11", "rec cleared", rec, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule